// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

A free-running up-counter guarded by a control register that only accepts writes carrying a fixed key byte. In watchdog mode, expiry of the selected period raises a one-cycle system-reset pulse. In interval mode, expiry sets a sticky interrupt flag and the count starts again, which gives a periodic tick. The block comes out of reset already armed as a watchdog on its longest period, counting the fast clock enable. Software must therefore restart or reconfigure it early.

A control write is a 16-bit word. The upper byte is the key and the lower byte holds the fields. A write with any other key is treated as a fault and causes an immediate reset pulse. Any reset pulse also returns the control fields to their power-up values and zeroes the count. The count advances on one of two clock enables, chosen by a source bit.

Top module: `wdt_timer`

## Requirements
- R1: After reset, ctrl_o reads 16'h6900: watchdog mode, hold off, fast source, period select 00. rst_o and irq_o are low.
- R2: A write with wr_data_i[15:8] equal to 8'h5A is accepted. Bit 7 is hold, bit 4 is interval mode (1) or watchdog mode (0), bit 2 selects the slow enable (1), and bits 1:0 are the period select. ctrl_o returns these bits in the same positions, 8'h69 in bits 15:8, and zero in bits 6, 5 and 3.
- R3: A write whose key byte is not 8'h5A gives rst_o high in the following cycle. It also returns ctrl_o to 16'h6900.
- R4: The period select picks the count length: 00 gives 32768 ticks, 01 gives 8192, 10 gives 512 and 11 gives 64. In watchdog mode, rst_o rises exactly that many ticks after a count restart.
- R5: In interval mode, expiry sets irq_o and never raises rst_o. The count then restarts, so expiries repeat every period.
- R6: irq_o stays set until an accepted write with bit 5 set clears it.
- R7: While hold is set, the count is frozen. Clearing hold resumes the count from the value it held.
- R8: An accepted write with bit 3 set restarts the count from zero. Bit 3 always reads back as zero.
- R9: With the source bit set, only cycles with clk_slow_en_i high advance the count. clk_fast_en_i has no effect.
- R10: rst_o is a single-cycle pulse. After a watchdog expiry, ctrl_o reads 16'h6900.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_fast_en_i | input | 1 | Fast count enable |
| clk_slow_en_i | input | 1 | Slow count enable |
| wr_en_i | input | 1 | Control write strobe |
| wr_data_i | input | 16 | Key byte and control fields |
| ctrl_o | output | 16 | Control register readback |
| rst_o | output | 1 | System-reset pulse |
| irq_o | output | 1 | Sticky interval interrupt flag |

## Verification
The bench builds the block with its default parameters: a 16-bit count and tap bits 14, 12, 8 and 5. All four periods can then be measured to the exact tick, including the full 32768-tick power-up period. This confirms that the select encoding maps each code to the right tap. Holding the slow enable low and then high makes the source-select and hold behaviour exact as well, rather than an approximate rate.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] KEY_WR = 8'h5A;
  localparam logic [7:0] KEY_RD = 8'h69;
  localparam int B_HOLD   = 7;
  localparam int B_IRQCLR = 5;
  localparam int B_MODE   = 4;
  localparam int B_CLR    = 3;
  localparam int B_SRC    = 2;

  typedef struct packed {
    logic       hold;
    logic       interval_mode;
    logic       src_slow;
    logic [1:0] isel;
  } wdt_cfg_t;

  localparam wdt_cfg_t CFG_DEFAULT = '{hold: 1'b0, interval_mode: 1'b0,
                                       src_slow: 1'b0, isel: 2'b00};
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  input  logic        restore_i,
  output wdt_cfg_t    cfg_o,
  output logic        cnt_clr_o,
  output logic        irq_clr_o,
  output logic        key_bad_o
);
  logic     wr_ok;
  wdt_cfg_t cfg_q, cfg_wr;

  assign wr_ok     = wr_en_i && (wr_data_i[15:8] == KEY_WR);
  assign key_bad_o = wr_en_i && (wr_data_i[15:8] != KEY_WR);
  assign cnt_clr_o = wr_ok && wr_data_i[B_CLR];
  assign irq_clr_o = wr_ok && wr_data_i[B_IRQCLR];

  always_comb begin
    cfg_wr.hold          = wr_data_i[B_HOLD];
    cfg_wr.interval_mode = wr_data_i[B_MODE];
    cfg_wr.src_slow      = wr_data_i[B_SRC];
    cfg_wr.isel          = wr_data_i[1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cfg_q <= CFG_DEFAULT;
    else if (restore_i) cfg_q <= CFG_DEFAULT;
    else if (wr_ok)     cfg_q <= cfg_wr;
  end

  assign cfg_o = cfg_q;

  // R3 / R10: a restore always lands on defaults
  a_r3_restore_default: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> (cfg_q == CFG_DEFAULT));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 16,
  parameter int TAP0  = 14,
  parameter int TAP1  = 12,
  parameter int TAP2  = 8,
  parameter int TAP3  = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       hold_i,
  input  logic       clr_i,
  input  logic [1:0] isel_i,
  output logic       expire_o
);
  localparam int N_TAP = 4;

  logic [N_TAP-1:0][CNT_W-1:0] mask;
  logic [CNT_W-1:0]            cnt_q, sel_mask;
  logic                        adv;

  for (genvar g = 0; g < N_TAP; g++) begin : g_mask
    localparam int TB = (g == 0) ? TAP0 : (g == 1) ? TAP1 : (g == 2) ? TAP2 : TAP3;
    assign mask[g] = CNT_W'((64'd1 << (TB + 1)) - 64'd1);
  end

  assign sel_mask = mask[isel_i];
  assign adv      = tick_i && !hold_i;
  assign expire_o = adv && ((cnt_q & sel_mask) == sel_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (expire_o) cnt_q <= '0;
    else if (adv)      cnt_q <= cnt_q + 1'b1;
  end

  a_r7_hold_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !clr_i) |=> $stable(cnt_q));
  a_r8_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  a_r9_idle_no_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_event.sv
module wdt_event (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic interval_i,
  input  logic key_bad_i,
  input  logic irq_clr_i,
  output logic restore_o,
  output logic rst_o,
  output logic irq_o
);
  logic rst_q, irq_q, wd_exp;

  assign wd_exp    = expire_i && !interval_i;
  assign restore_o = wd_exp || key_bad_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      rst_q <= restore_o;
      if (restore_o)                   irq_q <= 1'b0;
      else if (expire_i && interval_i) irq_q <= 1'b1;  // set wins over clear
      else if (irq_clr_i)              irq_q <= 1'b0;
    end
  end

  assign rst_o = rst_q;
  assign irq_o = irq_q;

  a_r10_rst_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_q && !key_bad_i) |=> !rst_q);
  a_r6_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !irq_clr_i && !restore_o) |=> irq_q);
  a_r5_no_reset_interval: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && interval_i && !key_bad_i) |=> (!rst_q && irq_q));
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TAP0  = 14,
  parameter int TAP1  = 12,
  parameter int TAP2  = 8,
  parameter int TAP3  = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clk_fast_en_i,
  input  logic        clk_slow_en_i,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  output logic [15:0] ctrl_o,
  output logic        rst_o,
  output logic        irq_o
);
  wdt_cfg_t cfg;
  logic     cnt_clr, irq_clr, key_bad, restore, expire, tick;

  assign tick = cfg.src_slow ? clk_slow_en_i : clk_fast_en_i;

  wdt_ctrl_reg u_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .restore_i (restore),
    .cfg_o     (cfg),
    .cnt_clr_o (cnt_clr),
    .irq_clr_o (irq_clr),
    .key_bad_o (key_bad)
  );

  wdt_counter #(.CNT_W(CNT_W), .TAP0(TAP0), .TAP1(TAP1), .TAP2(TAP2), .TAP3(TAP3)) u_cnt (
    .clk_i, .rst_ni,
    .tick_i   (tick),
    .hold_i   (cfg.hold),
    .clr_i    (cnt_clr || restore),
    .isel_i   (cfg.isel),
    .expire_o (expire)
  );

  wdt_event u_evt (
    .clk_i, .rst_ni,
    .expire_i   (expire),
    .interval_i (cfg.interval_mode),
    .key_bad_i  (key_bad),
    .irq_clr_i  (irq_clr),
    .restore_o  (restore),
    .rst_o, .irq_o
  );

  assign ctrl_o = {KEY_RD, cfg.hold, 2'b00, cfg.interval_mode, 1'b0, cfg.src_slow, cfg.isel};

  a_r3_bad_key_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[15:8] != KEY_WR) |=> rst_o);
  a_r8_clr_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[B_CLR]) |=> !ctrl_o[B_CLR]);
endmodule

// File: tb/wdt_timer_tb.sv
module wdt_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fast_en = 1'b1, slow_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] ctrl;
  logic        rst_p, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  wdt_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clk_fast_en_i(fast_en), .clk_slow_en_i(slow_en),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .ctrl_o(ctrl), .rst_o(rst_p), .irq_o(irq)
  );

  always #5 clk = ~clk;

  function automatic logic [15:0] word(bit hold, bit iclr, bit mode, bit clr, bit src, logic [1:0] isel);
    return {8'h5A, hold, 1'b0, iclr, mode, clr, src, isel};
  endfunction

  function automatic logic [15:0] exp_ctrl(logic [15:0] d);
    if (d[15:8] != 8'h5A) return 16'h6900;
    return {8'h69, d[7], 2'b00, d[4], 1'b0, d[2], d[1:0]};
  endfunction

  function automatic int period(logic [1:0] s);
    case (s)
      2'b00: return 32768;
      2'b01: return 8192;
      2'b10: return 512;
      default: return 64;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Counts negedges until the watched output rises; flags any rst_o when watching irq
  task automatic measure(bit watch_irq, output int n, output bit saw_rst);
    n = 0; saw_rst = 0;
    while (n < 40000) begin
      @(negedge clk);
      n++;
      if (rst_p) saw_rst = 1;
      if (watch_irq ? irq : rst_p) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n; bit sr;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 ctrl", ctrl, 16'h6900);
    chk("R1 rst", rst_p, 0);
    chk("R1 irq", irq, 0);

    // R4: power-up default period, measured from the first counting edge
    measure(0, n, sr);
    chk("R4 default /32768", n, 32768);
    @(negedge clk);
    chk("R10 pulse single", rst_p, 0);
    chk("R10 defaults after expiry", ctrl, 16'h6900);

    // R4: remaining selects in watchdog mode
    for (int s = 1; s < 4; s++) begin
      wr(word(0, 0, 0, 1, 0, 2'(s)));
      measure(0, n, sr);
      chk("R4 period", n, period(2'(s)));
      chk("R10 ctrl restored", ctrl, 16'h6900);
      @(negedge clk);
      chk("R10 pulse single", rst_p, 0);
    end

    // R5: interval mode periodic, no reset
    wr(word(0, 0, 1, 1, 0, 2'b11));
    measure(1, n, sr);
    chk("R5 first period", n, 64);
    chk("R5 no reset", sr, 0);
    repeat (30) @(negedge clk);
    chk("R6 sticky", irq, 1);
    wr(word(0, 1, 1, 1, 0, 2'b11));
    chk("R6 cleared", irq, 0);
    measure(1, n, sr);
    chk("R5 repeat period", n, 64);
    chk("R5 no reset again", sr, 0);

    // R7: hold freezes, release resumes from frozen value (zero)
    wr(word(1, 1, 1, 1, 0, 2'b11));
    repeat (200) @(negedge clk);
    chk("R7 held no irq", irq, 0);
    chk("R7 hold readback", ctrl, 16'h6993);
    wr(word(0, 0, 1, 0, 0, 2'b11));
    measure(1, n, sr);
    chk("R7 resume period", n, 64);

    // R8: clear mid-period restarts from zero
    wr(word(0, 1, 1, 1, 0, 2'b11));
    repeat (40) @(negedge clk);
    wr(word(0, 0, 1, 1, 0, 2'b11));
    measure(1, n, sr);
    chk("R8 restart", n, 64);

    // R9: slow source ignores fast enable
    slow_en = 1'b0;
    wr(word(0, 1, 1, 1, 1, 2'b11));
    repeat (300) @(negedge clk);
    chk("R9 fast ignored", irq, 0);
    slow_en = 1'b1;
    measure(1, n, sr);
    chk("R9 slow period", n, 64);
    slow_en = 1'b0;

    // R3: bad key
    wr(16'hA500 | 16'h0013);
    chk("R3 pulse", rst_p, 1);
    chk("R3 defaults", ctrl, 16'h6900);
    chk("R3 irq cleared", irq, 0);
    @(negedge clk);
    chk("R10 single after bad key", rst_p, 0);

    // R2/R3 random writes, count always cleared
    for (int i = 0; i < 40; i++) begin
      logic [15:0] d;
      d = 16'($urandom);
      if ($urandom % 4 != 0) d[15:8] = 8'h5A;
      d[3] = 1'b1;
      wr(d);
      chk(d[15:8] == 8'h5A ? "R2 readback" : "R3 readback", ctrl, exp_ctrl(d));
      chk(d[15:8] == 8'h5A ? "R2 no reset" : "R3 pulse", rst_p, d[15:8] != 8'h5A);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule